// File: doc/BRIEF.md
# Superscalar Register Rename Unit

This unit translates architectural register numbers into physical register numbers for a group of up to `SLOTS` instructions each cycle. It holds a map table (one physical index per architectural register), a ring-shaped free list of unused physical registers, and a small ring of branch checkpoints. Each checkpoint holds a copy of the map table and the free-list read position. The reorder buffer, issue logic and register file sit outside. The unit only sees commit events, which return the physical register an instruction displaced, and branch resolution events.

Renaming is combinational within the cycle. Every writing slot receives the next free physical register in slot order. Every source reads either the table or, when an earlier slot of the same group writes that architectural register, the register that slot just received. A chain of serially dependent instructions therefore renames in one cycle. Each slot also reports the mapping its destination displaced, so the reorder buffer can hand it back at commit. When a branch was mispredicted, its checkpoint restores the table. The free-list read pointer is rewound, so every register handed out after the branch is free again, in its original order.

`PHYS_N` and `CKPT_N` must be powers of two. A group may request at most one checkpoint, and the branch must be the group's last instruction.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register a maps to physical register a, and the free list holds ARCH_N..PHYS_N-1 with the lowest number handed out first. `out_stall` is low.
- R2: Each valid slot with `in_wr` set takes the next free-list entry in ascending slot order and reports it on `out_pdst`. Slots that do not write take no entry, and no two writers of one group get the same register.
- R3: Each valid source is reported as the physical register currently mapped to its architectural register in the table.
- R4: A source that names the destination of an earlier writing slot of the same group is reported as that slot's new register. When several earlier slots match, the nearest earlier one wins.
- R5: When several slots of a group write one architectural register, the last one sets the table. `out_pold` of each writer is the mapping it displaced: the table value, or the new register of the nearest earlier slot with the same destination.
- R6: If a group needs more registers than the free list holds, `out_stall` is high and `out_fire` low. Nothing in the unit changes.
- R7: Registers on `cm_preg` with `cm_vld` set are appended to the free list in ascending slot order, behind every register already free.
- R8: A fired group with `in_ckpt` set saves the post-group table and free-list position in checkpoint `out_ckpt_id`. Ids are handed out in ring order, starting at 0 after reset. With `CKPT_N` checkpoints outstanding, such a group stalls.
- R9: `rs_bad` with id k restores the table from checkpoint k and rewinds the free list to its saved position. It drops checkpoint k and every younger one, so the next id handed out is k. No group fires in that cycle.
- R10: `rs_ok` releases the oldest outstanding checkpoint, which frees its ring position for reuse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | SLOTS | Slot holds an instruction |
| in_wr | input | SLOTS | Slot writes a destination register |
| in_dst | input | SLOTS x AW | Architectural destination per slot |
| in_src1 | input | SLOTS x AW | First architectural source per slot |
| in_src2 | input | SLOTS x AW | Second architectural source per slot |
| in_ckpt | input | 1 | Group ends with a predicted branch; take a checkpoint |
| out_fire | output | 1 | Group is renamed this cycle |
| out_stall | output | 1 | Group blocked for lack of registers or checkpoints |
| out_pdst | output | SLOTS x PW | New physical destination per slot |
| out_psrc1 | output | SLOTS x PW | Physical first source per slot |
| out_psrc2 | output | SLOTS x PW | Physical second source per slot |
| out_pold | output | SLOTS x PW | Displaced physical mapping per writing slot |
| out_ckpt_id | output | CW | Checkpoint id given to this group's branch |
| cm_vld | input | SLOTS | Commit slot returns a register |
| cm_preg | input | SLOTS x PW | Physical register to return per commit slot |
| rs_ok | input | 1 | Oldest branch resolved correctly |
| rs_bad | input | 1 | Branch mispredicted |
| rs_id | input | CW | Checkpoint of the mispredicted branch |

## Verification
The bench renames a fully serial four-instruction chain. It then renames a group with two writers of the same register and readers placed between and after them. A unit that read only the table, or let the first writer win, would return stale registers there. It drains the free list to zero and checks that a one-register group stalls without moving the table. It also mispredicts a branch after later allocations, and expects the very register handed out after the branch to come back and the old mapping to be read again. Finally it fills every checkpoint, releases one, and trims the ring with a mispredict. A wrong ring count would give a wrong next id or a missing stall.

// File: rtl/rn_pkg.sv
package rn_pkg;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_OK,
        EV_BAD
    } rs_ev_t;

    function automatic int unsigned popcnt(input logic [31:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 32; i++) n += int'(v[i]);
        return n;
    endfunction

endpackage

// File: rtl/rn_freelist.sv
module rn_freelist #(
    parameter int PHYS_N = 16,
    parameter int ARCH_N = 8,
    parameter int SLOTS  = 4,
    parameter int CKPT_N = 4,
    localparam int PW = $clog2(PHYS_N),
    localparam int CW = $clog2(CKPT_N),
    localparam int FREE_MAX = PHYS_N - ARCH_N
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [SLOTS-1:0]           want,
    input  logic                       go,
    input  logic                       take,
    input  logic [CW-1:0]              take_id,
    input  logic                       restore,
    input  logic [CW-1:0]              restore_id,
    input  logic [SLOTS-1:0]           push_mask,
    input  logic [SLOTS-1:0][PW-1:0]   push_reg,
    output logic [SLOTS-1:0][PW-1:0]   grant,
    output logic [PW:0]                free_cnt
);
    logic [PW-1:0] mem [PHYS_N];
    logic [PW-1:0] snap_head [CKPT_N];
    logic [PW-1:0] head, tail;
    logic [PW:0]   cnt;
    logic [PW:0]   n_alloc, n_push;
    logic [SLOTS-1:0][PW-1:0] paddr;

    assign n_alloc  = go ? (PW+1)'(rn_pkg::popcnt(32'(want))) : '0;
    assign n_push   = (PW+1)'(rn_pkg::popcnt(32'(push_mask)));
    assign free_cnt = cnt;

    // read window: writers take entries in slot order
    always_comb begin
        logic [PW-1:0] r;
        r = '0;
        for (int i = 0; i < SLOTS; i++) begin
            grant[i] = mem[head + r];
            if (want[i]) r = r + PW'(1);
        end
    end

    // write window: returned registers packed behind the tail
    always_comb begin
        logic [PW-1:0] w;
        w = '0;
        for (int i = 0; i < SLOTS; i++) begin
            paddr[i] = tail + w;
            if (push_mask[i]) w = w + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < PHYS_N; k++)
                mem[k] <= (k < FREE_MAX) ? PW'(ARCH_N + k) : '0;
            for (int c = 0; c < CKPT_N; c++) snap_head[c] <= '0;
            head <= '0;
            tail <= PW'(FREE_MAX);
            cnt  <= (PW+1)'(FREE_MAX);
        end else begin
            for (int k = 0; k < SLOTS; k++)
                if (push_mask[k]) mem[paddr[k]] <= push_reg[k];
            tail <= tail + n_push[PW-1:0];
            if (restore) begin
                head <= snap_head[restore_id];
                cnt  <= cnt + (PW+1)'(PW'(head - snap_head[restore_id])) + n_push;
            end else begin
                head <= head + n_alloc[PW-1:0];
                cnt  <= cnt - n_alloc + n_push;
            end
            if (take) snap_head[take_id] <= head + n_alloc[PW-1:0];
        end
    end

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cnt <= (PW+1)'(FREE_MAX));

    p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
        go |-> n_alloc <= cnt);

endmodule

// File: rtl/rn_map.sv
module rn_map #(
    parameter int ARCH_N = 8,
    parameter int PHYS_N = 16,
    parameter int SLOTS  = 4,
    parameter int CKPT_N = 4,
    localparam int AW = $clog2(ARCH_N),
    localparam int PW = $clog2(PHYS_N),
    localparam int CW = $clog2(CKPT_N)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [SLOTS-1:0]           wr_mask,
    input  logic [SLOTS-1:0][AW-1:0]   dst,
    input  logic [SLOTS-1:0][PW-1:0]   pdst,
    input  logic [SLOTS-1:0][AW-1:0]   src1,
    input  logic [SLOTS-1:0][AW-1:0]   src2,
    output logic [SLOTS-1:0][PW-1:0]   rd1,
    output logic [SLOTS-1:0][PW-1:0]   rd2,
    output logic [SLOTS-1:0][PW-1:0]   rdd,
    input  logic                       take,
    input  logic [CW-1:0]              take_id,
    input  logic                       restore,
    input  logic [CW-1:0]              restore_id
);
    logic [PW-1:0] map     [ARCH_N];
    logic [PW-1:0] map_nxt [ARCH_N];
    logic [PW-1:0] snap    [CKPT_N][ARCH_N];

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            rd1[i] = map[src1[i]];
            rd2[i] = map[src2[i]];
            rdd[i] = map[dst[i]];
        end
    end

    // later slots overwrite earlier ones: last writer owns the entry
    always_comb begin
        map_nxt = map;
        for (int i = 0; i < SLOTS; i++)
            if (wr_mask[i]) map_nxt[dst[i]] = pdst[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < ARCH_N; a++) map[a] <= PW'(a);
            for (int c = 0; c < CKPT_N; c++)
                for (int a = 0; a < ARCH_N; a++) snap[c][a] <= PW'(a);
        end else begin
            if (restore) map <= snap[restore_id];
            else         map <= map_nxt;
            if (take) snap[take_id] <= map_nxt;
        end
    end

endmodule

// File: rtl/rn_xlate.sv
module rn_xlate #(
    parameter int SLOTS = 4,
    parameter int AW    = 3,
    parameter int PW    = 4
) (
    input  logic [SLOTS-1:0]           wmask,
    input  logic [SLOTS-1:0][AW-1:0]   dst,
    input  logic [SLOTS-1:0][PW-1:0]   pnew,
    input  logic [SLOTS-1:0][AW-1:0]   key,
    input  logic [SLOTS-1:0][PW-1:0]   tbl,
    output logic [SLOTS-1:0][PW-1:0]   res
);
    // compare against every earlier writer, nearest match last so it wins
    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            res[i] = tbl[i];
            for (int j = 0; j < SLOTS; j++)
                if (j < i && wmask[j] && dst[j] == key[i]) res[i] = pnew[j];
        end
    end

endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
    parameter int ARCH_N = 8,
    parameter int PHYS_N = 16,
    parameter int SLOTS  = 4,
    parameter int CKPT_N = 4,
    localparam int AW = $clog2(ARCH_N),
    localparam int PW = $clog2(PHYS_N),
    localparam int CW = $clog2(CKPT_N)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [SLOTS-1:0]           in_vld,
    input  logic [SLOTS-1:0]           in_wr,
    input  logic [SLOTS-1:0][AW-1:0]   in_dst,
    input  logic [SLOTS-1:0][AW-1:0]   in_src1,
    input  logic [SLOTS-1:0][AW-1:0]   in_src2,
    input  logic                       in_ckpt,
    output logic                       out_fire,
    output logic                       out_stall,
    output logic [SLOTS-1:0][PW-1:0]   out_pdst,
    output logic [SLOTS-1:0][PW-1:0]   out_psrc1,
    output logic [SLOTS-1:0][PW-1:0]   out_psrc2,
    output logic [SLOTS-1:0][PW-1:0]   out_pold,
    output logic [CW-1:0]              out_ckpt_id,
    input  logic [SLOTS-1:0]           cm_vld,
    input  logic [SLOTS-1:0][PW-1:0]   cm_preg,
    input  logic                       rs_ok,
    input  logic                       rs_bad,
    input  logic [CW-1:0]              rs_id
);
    import rn_pkg::*;

    logic [SLOTS-1:0]         wrm;
    logic [PW:0]              need, free_cnt;
    logic [SLOTS-1:0][PW-1:0] rd1, rd2, rdd;
    logic                     take, restore, ck_full, dup;
    logic [CW-1:0]            ck_head;
    logic [CW:0]              ck_cnt;
    rs_ev_t                   ev;

    assign wrm     = in_vld & in_wr;
    assign need    = (PW+1)'(popcnt(32'(wrm)));
    assign ck_full = ck_cnt == (CW+1)'(CKPT_N);
    assign ev      = rs_bad ? EV_BAD : (rs_ok ? EV_OK : EV_NONE);
    assign restore = ev == EV_BAD;

    assign out_stall   = (|in_vld) && ((need > free_cnt) || (in_ckpt && ck_full));
    assign out_fire    = (|in_vld) && !out_stall && !restore;
    assign take        = out_fire && in_ckpt;
    assign out_ckpt_id = ck_head + ck_cnt[CW-1:0];

    rn_freelist #(.PHYS_N(PHYS_N), .ARCH_N(ARCH_N), .SLOTS(SLOTS), .CKPT_N(CKPT_N)) u_free (
        .clk(clk), .rst(rst), .want(wrm), .go(out_fire),
        .take(take), .take_id(out_ckpt_id),
        .restore(restore), .restore_id(rs_id),
        .push_mask(cm_vld), .push_reg(cm_preg),
        .grant(out_pdst), .free_cnt(free_cnt)
    );

    rn_map #(.ARCH_N(ARCH_N), .PHYS_N(PHYS_N), .SLOTS(SLOTS), .CKPT_N(CKPT_N)) u_map (
        .clk(clk), .rst(rst), .wr_mask(out_fire ? wrm : '0),
        .dst(in_dst), .pdst(out_pdst), .src1(in_src1), .src2(in_src2),
        .rd1(rd1), .rd2(rd2), .rdd(rdd),
        .take(take), .take_id(out_ckpt_id),
        .restore(restore), .restore_id(rs_id)
    );

    rn_xlate #(.SLOTS(SLOTS), .AW(AW), .PW(PW)) u_xs1 (
        .wmask(wrm), .dst(in_dst), .pnew(out_pdst),
        .key(in_src1), .tbl(rd1), .res(out_psrc1)
    );

    rn_xlate #(.SLOTS(SLOTS), .AW(AW), .PW(PW)) u_xs2 (
        .wmask(wrm), .dst(in_dst), .pnew(out_pdst),
        .key(in_src2), .tbl(rd2), .res(out_psrc2)
    );

    rn_xlate #(.SLOTS(SLOTS), .AW(AW), .PW(PW)) u_xold (
        .wmask(wrm), .dst(in_dst), .pnew(out_pdst),
        .key(in_dst), .tbl(rdd), .res(out_pold)
    );

    // checkpoint ring: oldest at ck_head, ck_cnt outstanding
    always_ff @(posedge clk) begin
        if (rst) begin
            ck_head <= '0;
            ck_cnt  <= '0;
        end else begin
            unique case (ev)
                EV_BAD:  ck_cnt <= {1'b0, (rs_id - ck_head)};
                EV_OK: begin
                    ck_head <= ck_head + CW'(1);
                    ck_cnt  <= ck_cnt - (CW+1)'(1) + (CW+1)'(take);
                end
                default: ck_cnt <= ck_cnt + (CW+1)'(take);
            endcase
        end
    end

    always_comb begin
        dup = 1'b0;
        for (int i = 0; i < SLOTS; i++)
            for (int j = 0; j < SLOTS; j++)
                if (i < j && wrm[i] && wrm[j] && out_pdst[i] == out_pdst[j]) dup = 1'b1;
    end

    p_uniq_pdst_r2: assert property (@(posedge clk) disable iff (rst)
        out_fire |-> !dup);

    p_ck_bound_r8: assert property (@(posedge clk) disable iff (rst)
        ck_cnt <= (CW+1)'(CKPT_N));

    p_bad_shrink_r9: assert property (@(posedge clk) disable iff (rst)
        rs_bad |=> ck_cnt <= $past(ck_cnt));

    p_ok_pending_r10: assert property (@(posedge clk) disable iff (rst)
        (rs_ok && !rs_bad) |-> ck_cnt != '0);

endmodule

// File: tb/sim_rename_unit.sv
module sim_rename_unit;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [3:0]      in_vld, in_wr, cm_vld;
    logic [3:0][2:0] in_dst, in_src1, in_src2;
    logic [3:0][3:0] cm_preg;
    logic            in_ckpt, rs_ok, rs_bad;
    logic [1:0]      rs_id;
    logic            out_fire, out_stall;
    logic [3:0][3:0] out_pdst, out_psrc1, out_psrc2, out_pold;
    logic [1:0]      out_ckpt_id;

    rename_unit u0 (
        .clk(clk), .rst(rst),
        .in_vld(in_vld), .in_wr(in_wr), .in_dst(in_dst),
        .in_src1(in_src1), .in_src2(in_src2), .in_ckpt(in_ckpt),
        .out_fire(out_fire), .out_stall(out_stall),
        .out_pdst(out_pdst), .out_psrc1(out_psrc1), .out_psrc2(out_psrc2),
        .out_pold(out_pold), .out_ckpt_id(out_ckpt_id),
        .cm_vld(cm_vld), .cm_preg(cm_preg),
        .rs_ok(rs_ok), .rs_bad(rs_bad), .rs_id(rs_id)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic clr();
        in_vld = '0; in_wr = '0; in_dst = '0; in_src1 = '0; in_src2 = '0;
        in_ckpt = 1'b0; cm_vld = '0; cm_preg = '0;
        rs_ok = 1'b0; rs_bad = 1'b0; rs_id = '0;
    endtask

    // rename groups from reset state; values listed slot3..slot0
    localparam int NV = 4;
    localparam logic [3:0]      T_VLD [NV] = '{4'b1111, 4'b1111, 4'b0011, 4'b0001};
    localparam logic [3:0]      T_WR  [NV] = '{4'b1111, 4'b0101, 4'b0011, 4'b0001};
    localparam logic [3:0][2:0] T_DST [NV] = '{{3'd4,3'd3,3'd2,3'd1}, {3'd0,3'd1,3'd0,3'd1},
                                              {3'd0,3'd0,3'd6,3'd5}, {3'd0,3'd0,3'd0,3'd7}};
    localparam logic [3:0][2:0] T_S1  [NV] = '{{3'd3,3'd2,3'd1,3'd1}, {3'd1,3'd1,3'd1,3'd1},
                                              {3'd0,3'd0,3'd5,3'd1}, {3'd0,3'd0,3'd0,3'd0}};
    localparam logic [3:0][2:0] T_S2  [NV] = '{{3'd7,3'd6,3'd0,3'd5}, {3'd0,3'd3,3'd2,3'd4},
                                              {3'd0,3'd0,3'd6,3'd4}, {3'd0,3'd0,3'd0,3'd0}};
    localparam logic            E_FIRE[NV] = '{1'b1, 1'b1, 1'b1, 1'b0};
    localparam logic [3:0][3:0] E_PD  [NV] = '{{4'd11,4'd10,4'd9,4'd8}, {4'd0,4'd13,4'd0,4'd12},
                                              {4'd0,4'd0,4'd15,4'd14}, '0};
    localparam logic [3:0][3:0] E_P1  [NV] = '{{4'd10,4'd9,4'd8,4'd1}, {4'd13,4'd12,4'd12,4'd8},
                                              {4'd0,4'd0,4'd14,4'd13}, '0};
    localparam logic [3:0][3:0] E_P2  [NV] = '{{4'd7,4'd6,4'd0,4'd5}, {4'd0,4'd10,4'd9,4'd11},
                                              {4'd0,4'd0,4'd6,4'd11}, '0};
    localparam logic [3:0][3:0] E_PO  [NV] = '{{4'd4,4'd3,4'd2,4'd1}, {4'd0,4'd12,4'd0,4'd8},
                                              {4'd0,4'd0,4'd6,4'd5}, '0};

    initial begin
        #(20 * 5000);
        n_bad++;
        $display("FAIL watchdog R1 act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        clr();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: identity map after reset, no stall
        @(negedge clk); clr();
        in_vld = 4'b1111; in_src1 = {3'd3,3'd2,3'd1,3'd0}; in_src2 = {3'd7,3'd6,3'd5,3'd4};
        #5;
        chk("R1 stall", out_stall, 0);
        for (int s = 0; s < 4; s++) begin
            chk("R1 psrc1", out_psrc1[s], s);
            chk("R1 psrc2", out_psrc2[s], s + 4);
        end

        // table walk: R2..R6
        for (int v = 0; v < NV; v++) begin
            @(negedge clk); clr();
            in_vld = T_VLD[v]; in_wr = T_WR[v]; in_dst = T_DST[v];
            in_src1 = T_S1[v]; in_src2 = T_S2[v];
            #5;
            chk("R6 fire", out_fire, E_FIRE[v]);
            chk("R6 stall", out_stall, !E_FIRE[v]);
            if (E_FIRE[v]) begin
                for (int s = 0; s < 4; s++) begin
                    if (T_VLD[v][s]) begin
                        chk("R3/R4 psrc1", out_psrc1[s], E_P1[v][s]);
                        chk("R3/R4 psrc2", out_psrc2[s], E_P2[v][s]);
                    end
                    if (T_VLD[v][s] && T_WR[v][s]) begin
                        chk("R2 pdst", out_pdst[s], E_PD[v][s]);
                        chk("R5 pold", out_pold[s], E_PO[v][s]);
                    end
                end
            end
        end

        // R7: return registers 1 then 2
        @(negedge clk); clr();
        cm_vld = 4'b0011; cm_preg = {4'd0,4'd0,4'd2,4'd1};
        @(negedge clk); clr();
        in_vld = 4'b0001; in_wr = 4'b0001; in_dst[0] = 3'd7; in_src1[0] = 3'd7;
        #5;
        chk("R7 fire", out_fire, 1);
        chk("R7 pdst first returned", out_pdst[0], 1);
        chk("R6 stalled write left map", out_psrc1[0], 7);
        @(negedge clk); clr();
        in_vld = 4'b0001; in_wr = 4'b0001; in_dst[0] = 3'd0; in_src1[0] = 3'd7;
        #5;
        chk("R3 psrc after write", out_psrc1[0], 1);
        chk("R7 pdst second returned", out_pdst[0], 2);

        // R8/R9: checkpoint, allocate past it, mispredict
        @(negedge clk); clr();
        cm_vld = 4'b1111; cm_preg = {4'd6,4'd5,4'd4,4'd3};
        @(negedge clk); clr();
        in_vld = 4'b0001; in_wr = 4'b0001; in_dst[0] = 3'd1; in_src1[0] = 3'd1; in_ckpt = 1'b1;
        #5;
        chk("R8 fire", out_fire, 1);
        chk("R8 pdst", out_pdst[0], 3);
        chk("R8 ckpt id", out_ckpt_id, 0);
        @(negedge clk); clr();
        in_vld = 4'b0011; in_wr = 4'b0011; in_dst = {3'd0,3'd0,3'd2,3'd1};
        #5;
        chk("R2 pdst slot0", out_pdst[0], 4);
        chk("R2 pdst slot1", out_pdst[1], 5);
        @(negedge clk); clr();
        rs_bad = 1'b1; rs_id = 2'd0; in_vld = 4'b0001; in_wr = 4'b0001;
        #5;
        chk("R9 no fire on mispredict", out_fire, 0);
        @(negedge clk); clr();
        in_vld = 4'b0001; in_wr = 4'b0001; in_dst[0] = 3'd3;
        in_src1[0] = 3'd1; in_src2[0] = 3'd2;
        #5;
        chk("R9 restored r1", out_psrc1[0], 3);
        chk("R9 restored r2", out_psrc2[0], 9);
        chk("R9 register reissued", out_pdst[0], 4);

        // R8: fill all checkpoints, then stall
        for (int c = 0; c < 4; c++) begin
            @(negedge clk); clr();
            in_vld = 4'b0001; in_ckpt = 1'b1;
            #5;
            chk("R8 ring id", out_ckpt_id, c);
            chk("R8 fire", out_fire, 1);
        end
        @(negedge clk); clr();
        in_vld = 4'b0001; in_ckpt = 1'b1;
        #5;
        chk("R8 full stall", out_stall, 1);
        chk("R8 full no fire", out_fire, 0);

        // R10: release oldest, position reused
        @(negedge clk); clr();
        rs_ok = 1'b1;
        @(negedge clk); clr();
        in_vld = 4'b0001; in_ckpt = 1'b1;
        #5;
        chk("R10 stall cleared", out_stall, 0);
        chk("R10 reused id", out_ckpt_id, 0);

        // R9: trim ring from id 2
        @(negedge clk); clr();
        rs_bad = 1'b1; rs_id = 2'd2;
        @(negedge clk); clr();
        in_vld = 4'b0001; in_ckpt = 1'b1;
        #5;
        chk("R9 trimmed next id", out_ckpt_id, 2);
        chk("R9 fire after trim", out_fire, 1);

        @(negedge clk); clr();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule